// File: doc/BRIEF.md
# Digit-Serial Carry-Save Montgomery Multiplier

This block computes the Montgomery product P = X·Y·2^-K mod M for K-bit operands and an odd K-bit modulus M. A single-cycle `start` pulse latches X, Y and M. The block then retires D bits of X per clock through a chain of D radix-2 reduction steps. The running partial result is kept as a pair of (K+1)-bit carry and sum words, so no long carry chain appears in the loop. The quotient bit each step needs is produced one step early from the two low bits of that pair, which keeps it off the critical path.

When every bit of X has been used, a carry-skip adder with block size S merges the pair. The adder is given a fixed budget of W clock cycles. One more cycle subtracts M if the merged value is at least M, and the block then raises `done` for one cycle with P on `p_out`. Converting operands into and out of the Montgomery domain is left to the caller, and so is checking that X and Y are below M.

The controller has five states. IDLE waits for `start`. LOOP runs for K/D cycles. SETTLE waits W cycles while the adder output settles. CORR applies the conditional subtraction. FIN drives `done`. The transitions are: IDLE→LOOP on `start`, LOOP→SETTLE after the last digit, SETTLE→CORR after the W-th wait cycle, CORR→FIN and FIN→IDLE unconditionally.

Top module: `mont_ds_mul`

## Requirements
- R1: For odd M and X, Y < M, `p_out` equals X·Y·2^-K mod M while `done` is high. This holds for every digit width D that divides K, including D = 1, 2 and 4.
- R2: If `start` is sampled at clock edge 0, `done` is high in the cycle that follows edge K/D + W + 1.
- R3: `done` is high for exactly one cycle per accepted `start`.
- R4: Whenever `done` is high, `p_out` is below the latched modulus.
- R5: A `start` pulse, or a change on `x_in`, `y_in` or `m_in`, while an operation is in progress has no effect on that operation's result or timing.
- R6: After reset, `done` is low and `p_out` is zero.
- R7: In every LOOP cycle, the registered quotient bit equals the parity of (carry word bit 0 + sum word bit 0 + x_i·y_0), where x_i is the X bit being consumed. X bits above bit K-1 are read as zero.
- R8: The merged carry-save value that enters the correction step is below 2·M, so a single subtraction of M is enough.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only in IDLE) |
| x_in | input | K | Multiplier operand X |
| y_in | input | K | Multiplicand operand Y |
| m_in | input | K | Odd modulus M |
| p_out | output | K | Montgomery product, valid while `done` is high |
| done | output | 1 | One-cycle result strobe |

## Verification
The checker watches several properties on every cycle:
- the one-step-ahead quotient against the parity of the carry-save pair in each LOOP cycle;
- the bound below 2·M on the merged sum;
- the single-cycle `done` pulse and the result lying below the modulus;
- the latched modulus staying fixed while the block is busy.

Other properties only the bench's scenarios can show: the numerical result against an independent model for D = 1, 2 and 4, and the exact latency for each digit width. Operands with the top bit set, zero and unit operands, the largest modulus, M = 1, and inputs changed in the middle of an operation are covered by directed scenarios.

// File: rtl/mont_ds_pkg.sv
package mont_ds_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_LOOP   = 3'd1,
        S_SETTLE = 3'd2,
        S_CORR   = 3'd3,
        S_FIN    = 3'd4
    } mm_state_e;
endpackage

// File: rtl/mm_digit_cell.sv
// D chained radix-2 Montgomery steps on a carry-save pair, with look-ahead quotient.
module mm_digit_cell #(
    parameter int K = 64,
    parameter int D = 2
) (
    input  logic [K:0]   pc_i,
    input  logic [K:0]   ps_i,
    input  logic         q_i,
    input  logic [D:0]   xdig,
    input  logic [K-1:0] y,
    input  logic [K-1:0] m,
    output logic [K:0]   pc_o,
    output logic [K:0]   ps_o,
    output logic         q_o
);
    localparam int EW = K + 3;

    logic [K:0] pcs [D+1];
    logic [K:0] pss [D+1];
    logic       qs  [D+1];

    assign pcs[0] = pc_i;
    assign pss[0] = ps_i;
    assign qs[0]  = q_i;

    for (genvar g = 0; g < D; g++) begin : g_step
        logic [EW-1:0] a, b, xy, qm, s1, c1, s2, c2;
        assign a  = {2'b00, pcs[g]};
        assign b  = {2'b00, pss[g]};
        assign xy = xdig[g] ? {3'b000, y} : '0;
        assign qm = qs[g]   ? {3'b000, m} : '0;
        // two 3:2 compressor layers
        assign s1 = a ^ b ^ xy;
        assign c1 = ((a & b) | (a & xy) | (b & xy)) << 1;
        assign s2 = s1 ^ c1 ^ qm;
        assign c2 = ((s1 & c1) | (s1 & qm) | (c1 & qm)) << 1;
        // total is even by choice of quotient; halve each word
        assign pcs[g+1] = (K+1)'(c2 >> 1);
        assign pss[g+1] = (K+1)'(s2 >> 1);
        // next quotient from the two low bits only
        assign qs[g+1] = 1'(2'(pcs[g][1:0] + pss[g][1:0]
                               + (xdig[g] ? y[1:0] : 2'b00)
                               + (qs[g] ? m[1:0] : 2'b00)) >> 1)
                         ^ (xdig[g+1] & y[0]);
    end

    assign pc_o = pcs[D];
    assign ps_o = pss[D];
    assign q_o  = qs[D];
endmodule

// File: rtl/mm_skip_adder.sv
// Block carry-skip adder: ripple inside each S-bit block, bypass when all propagate.
module mm_skip_adder #(
    parameter int NB = 5,
    parameter int S  = 16
) (
    input  logic [NB*S-1:0] a,
    input  logic [NB*S-1:0] b,
    output logic [NB*S:0]   sum
);
    logic [NB:0] cy;
    assign cy[0] = 1'b0;

    for (genvar k = 0; k < NB; k++) begin : g_blk
        logic [S:0]   rc;
        logic [S-1:0] ab, pr;
        assign ab = a[k*S +: S];
        assign pr = ab ^ b[k*S +: S];
        always_comb begin
            rc[0] = cy[k];
            for (int j = 0; j < S; j++) begin
                rc[j+1] = (ab[j] & b[k*S+j]) | (pr[j] & rc[j]);
            end
        end
        assign sum[k*S +: S] = pr ^ rc[S-1:0];
        assign cy[k+1] = (&pr) ? cy[k] : rc[S];
    end

    assign sum[NB*S] = cy[NB];
endmodule

// File: rtl/mont_ds_mul.sv
module mont_ds_mul
    import mont_ds_pkg::*;
#(
    parameter int K = 64,
    parameter int D = 2,
    parameter int S = 16,
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [K-1:0] x_in,
    input  logic [K-1:0] y_in,
    input  logic [K-1:0] m_in,
    output logic [K-1:0] p_out,
    output logic         done
);
    localparam int NDIG = K / D;
    localparam int CMAX = (NDIG > W) ? NDIG : W;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int NB   = (K + S) / S;
    localparam int AW   = NB * S;

    if ((K % D) != 0 || D >= K || W < 1) begin : g_bad_cfg
        $error("mont_ds_mul: K must be a multiple of D, D < K, W >= 1");
    end

    mm_state_e      state, state_n;
    logic [CW-1:0]  cnt;
    logic [K-1:0]   xsh, y_r, m_r, p_r;
    logic [K:0]     pc_r, ps_r, pc_n, ps_n;
    logic           q_r, q_n;
    logic [AW:0]    add_sum, sum_r, m_ext;

    mm_digit_cell #(.K(K), .D(D)) u_cell (
        .pc_i (pc_r),
        .ps_i (ps_r),
        .q_i  (q_r),
        .xdig (xsh[D:0]),
        .y    (y_r),
        .m    (m_r),
        .pc_o (pc_n),
        .ps_o (ps_n),
        .q_o  (q_n)
    );

    mm_skip_adder #(.NB(NB), .S(S)) u_add (
        .a   ({{(AW-K-1){1'b0}}, pc_r}),
        .b   ({{(AW-K-1){1'b0}}, ps_r}),
        .sum (add_sum)
    );

    assign m_ext = {{(AW+1-K){1'b0}}, m_r};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (start) state_n = S_LOOP;
            S_LOOP:   if (cnt == CW'(NDIG - 1)) state_n = S_SETTLE;
            S_SETTLE: if (cnt == CW'(W - 1)) state_n = S_CORR;
            S_CORR:   state_n = S_FIN;
            S_FIN:    state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            xsh   <= '0;
            y_r   <= '0;
            m_r   <= '0;
            pc_r  <= '0;
            ps_r  <= '0;
            q_r   <= 1'b0;
            sum_r <= '0;
            p_r   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    xsh  <= x_in;
                    y_r  <= y_in;
                    m_r  <= m_in;
                    pc_r <= '0;
                    ps_r <= '0;
                    q_r  <= x_in[0] & y_in[0];
                    cnt  <= '0;
                end
                S_LOOP: begin
                    pc_r <= pc_n;
                    ps_r <= ps_n;
                    q_r  <= q_n;
                    xsh  <= xsh >> D;
                    cnt  <= (cnt == CW'(NDIG - 1)) ? '0 : cnt + 1'b1;
                end
                S_SETTLE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(W - 1)) sum_r <= add_sum;
                end
                S_CORR: p_r <= (sum_r >= m_ext) ? K'(sum_r - m_ext) : K'(sum_r);
                S_FIN: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done  = (state == S_FIN);
        p_out = p_r;
    end
endmodule

// File: rtl/mont_ds_mul_chk.sv
module mont_ds_mul_chk
    import mont_ds_pkg::*;
#(
    parameter int K  = 64,
    parameter int AW = 80
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic [K-1:0] p_out,
    input mm_state_e    state,
    input logic [K-1:0] m_r,
    input logic [K-1:0] y_r,
    input logic [K-1:0] xsh,
    input logic [K:0]   pc_r,
    input logic [K:0]   ps_r,
    input logic         q_r,
    input logic [AW:0]  sum_r
);
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_result_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (p_out < m_r));

    a_r5_busy_holds_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && start) |=> $stable(m_r));

    a_r7_quotient_lookahead: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOOP) |-> (q_r == (pc_r[0] ^ ps_r[0] ^ (xsh[0] & y_r[0]))));

    a_r8_merge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CORR) |-> ({1'b0, sum_r} < {{(AW+1-K){1'b0}}, m_r, 1'b0}));
endmodule

bind mont_ds_mul mont_ds_mul_chk #(.K(K), .AW(AW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .done  (done),
    .p_out (p_out),
    .state (state),
    .m_r   (m_r),
    .y_r   (y_r),
    .xsh   (xsh),
    .pc_r  (pc_r),
    .ps_r  (ps_r),
    .q_r   (q_r),
    .sum_r (sum_r)
);

// File: tb/mont_ds_mul_test.sv
`timescale 1ns/1ps
module mont_ds_mul_test;
    localparam int K = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [K-1:0] x_in = '0, y_in = '0, m_in = 32'd1;
    logic [K-1:0] p2, p1, p4;
    logic         d2, d1, d4;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mont_ds_mul #(.K(K), .D(2), .S(8), .W(2)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
        .m_in(m_in), .p_out(p2), .done(d2));
    mont_ds_mul #(.K(K), .D(1), .S(8), .W(3)) uut_d1 (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
        .m_in(m_in), .p_out(p1), .done(d1));
    mont_ds_mul #(.K(K), .D(4), .S(16), .W(1)) uut_d4 (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
        .m_in(m_in), .p_out(p4), .done(d4));

    function automatic longint unsigned ref_mont(longint unsigned x, longint unsigned y,
                                                 longint unsigned m);
        longint unsigned t = (x * y) % m;
        for (int i = 0; i < K; i++) begin
            if (t[0]) t = t + m;
            t = t >> 1;
        end
        return t;
    endfunction

    task automatic check(bit ok, string req, string what, longint unsigned act,
                         longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_op(logic [K-1:0] xa, logic [K-1:0] ya, logic [K-1:0] ma,
                          bit disturb);
        longint unsigned exp = ref_mont(xa, ya, ma);
        int lat [3] = '{-1, -1, -1};
        int cnt [3] = '{0, 0, 0};
        longint unsigned res [3] = '{0, 0, 0};
        int explat [3];
        explat[0] = K/2 + 2 + 1;
        explat[1] = K/1 + 3 + 1;
        explat[2] = K/4 + 1 + 1;
        @(negedge clk);
        x_in = xa; y_in = ya; m_in = ma; start = 1'b1;
        @(posedge clk);
        for (int n = 0; n < K + 12; n++) begin
            @(negedge clk);
            if (n == 0) start = 1'b0;
            if (disturb && n == 3) begin
                start = 1'b1; x_in = ~xa; y_in = ya ^ 32'h5a5a; m_in = ma ^ 32'h0000_0f00;
            end
            if (disturb && n == 4) start = 1'b0;
            if (d2) begin cnt[0]++; if (lat[0] < 0) begin lat[0] = n; res[0] = p2; end end
            if (d1) begin cnt[1]++; if (lat[1] < 0) begin lat[1] = n; res[1] = p1; end end
            if (d4) begin cnt[2]++; if (lat[2] < 0) begin lat[2] = n; res[2] = p4; end end
            @(posedge clk);
        end
        for (int i = 0; i < 3; i++) begin
            check(res[i] == exp, disturb ? "R5" : "R1", $sformatf("product inst%0d", i),
                  res[i], exp);
            check(lat[i] == explat[i], disturb ? "R5" : "R2", $sformatf("latency inst%0d", i),
                  lat[i], explat[i]);
            check(cnt[i] == 1, "R3", $sformatf("done cycles inst%0d", i), cnt[i], 1);
            check(res[i] < ma, "R4", $sformatf("range inst%0d", i), res[i], ma);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [K-1:0] mr, xr, yr;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R6 reset state
        check(d2 == 0 && d1 == 0 && d4 == 0, "R6", "done in reset", {d2, d1, d4}, 0);
        check(p2 == 0 && p1 == 0 && p4 == 0, "R6", "p_out in reset", p2 | p1 | p4, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(d2 == 0 && d1 == 0 && d4 == 0, "R6", "done after reset", {d2, d1, d4}, 0);

        // directed corners (R7: top X bit set exercises zero above bit K-1)
        run_op(32'd0, 32'd12345, 32'd65537, 1'b0);
        run_op(32'd1, 32'd1, 32'hFFFF_FFFF, 1'b0);
        run_op(32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0);
        run_op(32'h8000_0001, 32'h7FFF_FFFF, 32'hFFFF_FFFB, 1'b0);
        run_op(32'd0, 32'd0, 32'd1, 1'b0);
        run_op(32'd2, 32'd2, 32'd3, 1'b0);
        // R5 disturbance while busy
        run_op(32'h1234_5679, 32'h0ABC_DEF1, 32'hF000_0001, 1'b1);
        run_op(32'hC000_0003, 32'h8000_0005, 32'hE123_4567, 1'b1);

        // R1/R8 random odd moduli of varied size
        for (int t = 0; t < 40; t++) begin
            mr = ($urandom() >> ($urandom() % 24)) | 32'h1;
            xr = $urandom() % mr;
            yr = $urandom() % mr;
            run_op(xr, yr, mr, (t % 8) == 7);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule